// File: doc/BRIEF.md
# Register-Port I2C Slave Engine

This block is the serial front end of a small control chip. It listens on a two-wire I2C bus as a slave and turns bus writes into single-cycle write strobes toward a local register bank. It samples SCL and SDA in the system clock domain. It recognises start, repeated-start and stop conditions, and it answers only to its own 7-bit address. SDA is driven through a single pull-low output, so the pad is open-drain.

The upper four address bits are a fixed prefix. The lower three come from strap pins. A write carries one sub-address byte and then any number of data bytes. Each data byte is written to the current sub-address, and the sub-address then moves on by one. A read has no sub-address phase. The engine fetches one status byte from the bank as the read starts and shifts it out MSB first. The system clock must run at least eight times faster than SCL.

Top module: `i2c_regport_slave`

## Requirements
- R1: While reset is held and right after it, `sda_pull` is 0 and neither `wr_en` nor `rd_req` is asserted.
- R2: After a start, an address byte whose bits [7:1] equal binary 1001 followed by `addr_sel[2]`, `addr_sel[1]`, `addr_sel[0]` is acknowledged: SDA is held low through the ninth clock. Bit 0 selects the direction: 0 is a write to the slave and 1 is a read from it.
- R3: An address byte with any other value in bits [7:1] gets no acknowledge. Every later byte is then ignored, with no acknowledge and no write, until the next start.
- R4: In a write, the byte after the address is taken as the sub-address and acknowledged. Each following byte is acknowledged and produces one `wr_en` pulse carrying that byte on `wr_data` and the current sub-address on `wr_addr`. The pulse comes in the same cycle that the slave begins its acknowledge.
- R5: After each written byte the sub-address advances by one, wrapping from 255 to 0.
- R6: In a read, `rd_req` pulses once at the end of the address acknowledge and the `rd_data` value of that cycle is shifted out MSB first, one bit per SCL period. SDA is released for the master's acknowledge bit and stays released until the next start.
- R7: A stop condition (SDA rising while SCL is high) ends the transfer. Bytes clocked after a stop and before the next start are neither acknowledged nor written.
- R8: A repeated start at any point drops a partly received byte without writing it and restarts address reception.
- R9: `sda_pull` changes only while SCL is low.
- R10: `wr_en` and `rd_req` are each high for exactly one system clock per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 3 | Strap pins giving the low three address bits |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Sub-address of the write |
| wr_data | output | 8 | Data byte of the write |
| rd_req | output | 1 | One-cycle strobe when the status byte is taken |
| rd_data | input | 8 | Status byte from the register bank |

## Verification
The write strobe and the sub-address advance happen in the same clock edge. A wrong ordering shows up as a burst landing one register off. The bench starts a burst at sub-address 254 so that the advance wraps during the burst, and it checks that the captured strobes carry 254, 255 and 0 in turn. A second collision is a repeated start that arrives while a data byte is half shifted in. The bench sends four data bits and then a new start, and it passes only if the single strobe that follows belongs to the second transfer.

// File: rtl/i2cs_pkg.sv
// Package: shared types of the register-port I2C slave.
// Assumes nothing beyond IEEE 1800-2017 enums.
package i2cs_pkg;

    // Protocol phase of the slave engine
    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for a start
        ST_ADDR,   // shifting in the address byte
        ST_AACK,   // acknowledging the address
        ST_SUB,    // shifting in the sub-address
        ST_SACK,   // acknowledging the sub-address
        ST_DATA,   // shifting in a write data byte
        ST_DACK,   // acknowledging a data byte
        ST_TX,     // shifting out the status byte
        ST_MACK,   // master acknowledge slot after the read byte
        ST_SKIP    // not addressed, wait for the next start
    } bus_state_t;

endpackage

// File: rtl/i2cs_sync.sv
// Module: multi-stage synchronizer, one independent chain per line.
// Assumes the lines are slow compared to clk; the reset value models an idle bus.
module i2cs_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain;
            // Shift the asynchronous line through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din[g]};
            end
            assign dout[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/i2cs_events.sv
// Module: bus event detector. It keeps the previous synchronized sample of each
// line and reports SCL edges plus start and stop conditions.
// Assumes synchronized inputs; a condition needs SCL high in both samples.
module i2cs_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_q;
    logic sda_q;

    // Remember last cycle's line levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cs_rxbyte.sv
// Module: receive shifter. It takes one bit per enabled SCL rise, MSB first,
// and flags a full byte. It holds once full until cleared.
// Assumes the controller clears it at byte boundaries and on start.
module i2cs_rxbyte #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] data,
    output logic         full
);

    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    // Collect bits and count them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            cnt  <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (shift && !full) begin
            data <= {data[W-2:0], bit_in};
            cnt  <= cnt + 1'b1;
        end
    end

    assign full = (cnt == CW'(W));

endmodule

// File: rtl/i2c_regport_slave.sv
// Module: I2C slave protocol engine with register-bank write port and
// single status-byte read. It synchronizes the bus lines, decodes the
// conditions, matches a prefix-plus-strap address, and drives SDA low only
// while SCL is low.
// Assumes clk >= 8x SCL; 7-bit addressing; no clock stretching.
module i2c_regport_slave
    import i2cs_pkg::*;
#(
    parameter int         SUB_W       = 8,
    parameter int         SEL_W       = 3,
    parameter int         PFX_W       = 4,
    parameter logic [3:0] ADDR_PREFIX = 4'b1001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [SEL_W-1:0] addr_sel,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [SUB_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             rd_req,
    input  logic [7:0]       rd_data
);

    localparam int BYTE_W = 8;
    localparam int ADDR_W = PFX_W + SEL_W;

    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_ev, stop_ev;
    logic              rx_clr, rx_shift, rx_full;
    logic [BYTE_W-1:0] rx_byte;
    logic              addr_hit;
    bus_state_t        state;
    logic              dir_rd;
    logic [SUB_W-1:0]  sub_ptr;
    logic [BYTE_W-1:0] tx_sr;
    logic [2:0]        tx_cnt;

    i2cs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout ({scl_s, sda_s})
    );

    i2cs_events u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    // Shift only in phases that receive a byte; clear on start or byte end
    assign rx_shift = scl_rise &&
                      (state == ST_ADDR || state == ST_SUB || state == ST_DATA);
    assign rx_clr   = start_ev || (scl_fall && rx_full);

    i2cs_rxbyte #(.W(BYTE_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .shift (rx_shift),
        .bit_in(sda_s),
        .data  (rx_byte),
        .full  (rx_full)
    );

    assign addr_hit = (rx_byte[BYTE_W-1:1] == ADDR_W'({ADDR_PREFIX, addr_sel}));

    // Protocol sequencer: phase changes, SDA drive, strobes and the sub-address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            rd_req   <= 1'b0;
            dir_rd   <= 1'b0;
            sub_ptr  <= '0;
            tx_sr    <= '0;
            tx_cnt   <= '0;
        end else begin
            wr_en  <= 1'b0;
            rd_req <= 1'b0;
            if (start_ev) begin
                state    <= ST_ADDR;
                sda_pull <= 1'b0;
            end else if (stop_ev) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (scl_fall) begin
                unique case (state)
                    ST_ADDR: if (rx_full) begin
                        if (addr_hit) begin
                            state    <= ST_AACK;
                            sda_pull <= 1'b1;
                            dir_rd   <= rx_byte[0];
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                    ST_AACK: begin
                        if (dir_rd) begin
                            state    <= ST_TX;
                            tx_sr    <= rd_data;
                            tx_cnt   <= '0;
                            rd_req   <= 1'b1;
                            sda_pull <= ~rd_data[7];
                        end else begin
                            state    <= ST_SUB;
                            sda_pull <= 1'b0;
                        end
                    end
                    ST_SUB: if (rx_full) begin
                        sub_ptr  <= rx_byte[SUB_W-1:0];
                        state    <= ST_SACK;
                        sda_pull <= 1'b1;
                    end
                    ST_SACK: begin
                        state    <= ST_DATA;
                        sda_pull <= 1'b0;
                    end
                    ST_DATA: if (rx_full) begin
                        wr_en    <= 1'b1;
                        wr_addr  <= sub_ptr;
                        wr_data  <= rx_byte;
                        sub_ptr  <= sub_ptr + 1'b1;
                        state    <= ST_DACK;
                        sda_pull <= 1'b1;
                    end
                    ST_DACK: begin
                        state    <= ST_DATA;
                        sda_pull <= 1'b0;
                    end
                    ST_TX: begin
                        if (tx_cnt == 3'd7) begin
                            state    <= ST_MACK;
                            sda_pull <= 1'b0;
                        end else begin
                            tx_sr    <= {tx_sr[BYTE_W-2:0], 1'b0};
                            tx_cnt   <= tx_cnt + 1'b1;
                            sda_pull <= ~tx_sr[BYTE_W-2];
                        end
                    end
                    ST_MACK: state <= ST_SKIP;
                    default: state <= state;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cs_chk.sv
// Module: property checker for the register-port I2C slave, bound to the top.
// Assumes the synchronized SCL and the event flags of the top are visible.
module i2cs_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_ev,
    input logic stop_ev,
    input logic sda_pull,
    input logic wr_en,
    input logic rd_req
);

    // R9
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s);

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_pull);

    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_pull);

    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R4
    wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_pull);

endmodule

bind i2c_regport_slave i2cs_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .sda_pull(sda_pull),
    .wr_en   (wr_en),
    .rd_req  (rd_req)
);

// File: tb/sim_i2c_regport_slave.sv
// Bench: bit-banged bus master sweeping addresses, write bursts and reads.
module sim_i2c_regport_slave;

    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] addr_sel = 3'd0;
    logic [7:0] rd_data = 8'h00;
    logic       sda_pull, wr_en, rd_req;
    logic [7:0] wr_addr, wr_data;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;
    int ncap = 0;
    int nrd = 0;
    int bad_r9 = 0;
    logic [7:0] cap_a [0:63];
    logic [7:0] cap_d [0:63];
    logic prev_pull = 1'b0;
    bit done = 0;

    assign sda_bus = sda_m & ~sda_pull;

    always #5 clk = ~clk;

    i2c_regport_slave u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_m),
        .sda_in  (sda_bus),
        .addr_sel(addr_sel),
        .sda_pull(sda_pull),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_req  (rd_req),
        .rd_data (rd_data)
    );

    // Port monitor: record strobes, watch SDA drive against raw SCL
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en && ncap < 64) begin
                cap_a[ncap] = wr_addr;
                cap_d[ncap] = wr_data;
                ncap++;
            end
            if (rd_req) nrd++;
            if (sda_pull !== prev_pull && scl_m) bad_r9++;
        end
        prev_pull = sda_pull;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic v, output logic s);
        tick(2);
        sda_m = v;
        tick(H);
        scl_m = 1'b1;
        tick(H / 2);
        s = sda_bus;
        tick(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        tick(2);
        sda_m = 1'b1;
        tick(H);
        scl_m = 1'b1;
        tick(H);
        sda_m = 1'b0;
        tick(H);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(2);
        sda_m = 1'b0;
        tick(H);
        scl_m = 1'b1;
        tick(H);
        sda_m = 1'b1;
        tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(!mack, s);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] b;
        int base;
        logic s;

        // R1: reset state
        tick(4);
        chk(!sda_pull && !wr_en && !rd_req, "R1 in reset", int'(sda_pull), 0);
        rst_n = 1'b1;
        tick(4);
        chk(!sda_pull && !wr_en && !rd_req, "R1 after reset", int'(sda_pull), 0);

        // R2/R3: sweep strap pins against every low address value
        for (int sv = 0; sv < 8; sv++) begin
            addr_sel = 3'(sv);
            for (int a = 0; a < 8; a++) begin
                base = ncap;
                bus_start();
                send_byte({4'b1001, 3'(a), 1'b0}, ack);
                chk(ack == (a == sv), "R2/R3 address ack", int'(ack), int'(a == sv));
                send_byte(8'h40 + 8'(a), ack);
                chk(ack == (a == sv), "R3 second byte ack", int'(ack), int'(a == sv));
                send_byte(8'h5A, ack);
                bus_stop();
                chk(ncap == base + ((a == sv) ? 1 : 0), "R3 write count", ncap - base,
                    (a == sv) ? 1 : 0);
            end
        end

        // R3: wrong prefix never answered
        addr_sel = 3'd5;
        for (int p = 0; p < 16; p++) begin
            if (p != 9) begin
                bus_start();
                send_byte({4'(p), 3'd5, 1'b0}, ack);
                chk(!ack, "R3 prefix mismatch", int'(ack), 0);
                bus_stop();
            end
        end

        // R4/R5: burst crossing the sub-address wrap
        base = ncap;
        bus_start();
        send_byte({4'b1001, 3'd5, 1'b0}, ack);
        chk(ack, "R2 write address ack", int'(ack), 1);
        send_byte(8'hFE, ack);
        chk(ack, "R4 sub-address ack", int'(ack), 1);
        for (int k = 0; k < 3; k++) begin
            send_byte(8'h11 * 8'(k + 1), ack);
            chk(ack, "R4 data ack", int'(ack), 1);
        end
        bus_stop();
        chk(ncap == base + 3, "R4 burst write count", ncap - base, 3);
        for (int k = 0; k < 3; k++) begin
            chk(cap_a[base + k] == 8'(8'hFE + k), "R5 write address", cap_a[base + k],
                8'(8'hFE + k));
            chk(cap_d[base + k] == 8'h11 * 8'(k + 1), "R4 write data", cap_d[base + k],
                8'h11 * 8'(k + 1));
        end

        // R7: bytes after a stop without a new start are ignored
        base = ncap;
        send_byte({4'b1001, 3'd5, 1'b0}, ack);
        chk(!ack, "R7 no ack after stop", int'(ack), 0);
        send_byte(8'h03, ack);
        send_byte(8'h99, ack);
        chk(!ack && ncap == base, "R7 no write after stop", ncap - base, 0);
        bus_stop();

        // R8: repeated start in the middle of a data byte
        base = ncap;
        bus_start();
        send_byte({4'b1001, 3'd5, 1'b0}, ack);
        send_byte(8'h10, ack);
        clock_bit(1'b1, s);
        clock_bit(1'b0, s);
        clock_bit(1'b1, s);
        clock_bit(1'b0, s);
        bus_start();
        send_byte({4'b1001, 3'd5, 1'b0}, ack);
        chk(ack, "R8 address after repeated start", int'(ack), 1);
        send_byte(8'h20, ack);
        send_byte(8'h77, ack);
        bus_stop();
        chk(ncap == base + 1, "R8 single write", ncap - base, 1);
        chk(cap_a[base] == 8'h20 && cap_d[base] == 8'h77, "R8 write target",
            {cap_a[base], cap_d[base]}, 16'h2077);

        // R6: read sweep over status values
        for (int k = 0; k < 8; k++) begin
            int r0;
            rd_data = 8'(k * 37) ^ 8'hC3;
            r0 = nrd;
            bus_start();
            send_byte({4'b1001, 3'd5, 1'b1}, ack);
            chk(ack, "R2 read address ack", int'(ack), 1);
            recv_byte(1'b0, b);
            chk(b == rd_data, "R6 read byte", b, rd_data);
            chk(nrd == r0 + 1, "R6/R10 one read strobe", nrd - r0, 1);
            recv_byte(1'b0, b);
            chk(b == 8'hFF, "R6 released after read", b, 8'hFF);
            bus_stop();
        end

        // R9: drive changes only while SCL low
        chk(bad_r9 == 0, "R9 drive while SCL high", bad_r9, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule